// File: doc/BRIEF.md
# Move Instruction Decoder with Destination Prefix

The block splits 16-bit move instruction words into the pieces a register-transport datapath needs: a flag telling whether the source is a literal or a register, the 8-bit literal, the source module and register index, the destination module and an extended destination index. Every operation in this style of machine is a move between registers, so these fields are all a datapath needs to route one transfer per cycle. The datapath then performs the transfer, and any side effects of special registers are left to it.

The destination field carries only a 3-bit register subindex, while the source field carries a 4-bit one. To reach registers 8 to 31 of a module as a destination, software first writes a prefix register. That write is itself a move instruction aimed at a fixed destination address, and it costs one extra instruction cycle. The stored prefix supplies the two high bits of the 5-bit destination index for the next decoded move only, and then clears itself.

All results are registered. A completed move is signalled by a one-cycle strobe in the cycle after the instruction was presented. Between completed moves the output fields keep their values.

Top module: `move_decoder`

## Requirements
- R1: After reset, `mv_done_o` is low, every output field is zero and the stored prefix is zero. A reset asserted while a prefix is pending discards it.
- R2: A valid instruction that is not a prefix write produces exactly one `mv_done_o` pulse, in the next cycle. Back-to-back valid moves give back-to-back pulses, and there is no pulse without a valid move.
- R3: When bit 15 is 0, the move has an immediate source. The result then has `src_is_imm_o`=1, `imm_o`=bits 7:0, and `src_mod_o` and `src_idx_o` both zero.
- R4: When bit 15 is 1, the move has a register source. The result then has `src_is_imm_o`=0, `src_mod_o`=bits 3:0, `src_idx_o`=bits 7:4 and `imm_o`=0.
- R5: `dst_mod_o` equals bits 11:8. `dst_idx_o[2:0]` equals bits 14:12. `dst_idx_o[4:3]` equals the pending prefix, which is 0 when no prefix is pending.
- R6: A valid instruction with bits 11:8 = 4'hB and bits 14:12 = 0 is a prefix write. It gives no `mv_done_o` pulse and leaves every output unchanged. It stores bits 1:0 of the word in immediate form, or `pfx_wdata_i` in register form.
- R7: A prefix applies only to the next valid move, after which it is zero. Idle cycles between the prefix write and that move do not clear it.
- R8: When two prefix writes follow each other, the later value is the one used.
- R9: While `instr_valid_i` is low, the instruction word is ignored, even if it encodes a prefix write. The outputs hold, no pulse appears, and the pending prefix is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 16 | Instruction word |
| pfx_wdata_i | input | 2 | Prefix value for a register-form prefix write |
| mv_done_o | output | 1 | One-cycle strobe marking a decoded move |
| src_is_imm_o | output | 1 | Source is an immediate |
| imm_o | output | 8 | Immediate source value |
| src_mod_o | output | 4 | Source module |
| src_idx_o | output | 4 | Source register index |
| dst_mod_o | output | 4 | Destination module |
| dst_idx_o | output | 5 | Extended destination index |

## Verification
The decoder is driven with:
- single immediate and register moves, which separate the two source formats and catch swapped nibbles;
- back-to-back moves, which show one strobe per word with no gaps or duplicates;
- a prefix followed by two moves, which shows that the prefix is used exactly once;
- prefixes separated by idle cycles, and idle cycles carrying a prefix-shaped word, which show that only valid cycles change the prefix;
- two prefixes in a row, in both forms, which show that the last write wins and that the value comes from the correct place.

A reset issued while a prefix is pending shows that the prefix is cleared rather than held.

// File: rtl/mvd_pkg.sv
package mvd_pkg;
  localparam int unsigned INSTR_W = 16;
  localparam int unsigned IMM_W   = 8;
  localparam int unsigned MOD_W   = 4;
  localparam int unsigned SIDX_W  = 4;
  localparam int unsigned DSUB_W  = 3;
  localparam int unsigned PFX_W   = 2;
  localparam int unsigned DIDX_W  = DSUB_W + PFX_W;
  localparam int unsigned FMT_BIT = INSTR_W - 1;
  localparam int unsigned DST_LSB = IMM_W;

  typedef struct packed {
    logic              is_imm;
    logic [IMM_W-1:0]  imm;
    logic [MOD_W-1:0]  src_mod;
    logic [SIDX_W-1:0] src_idx;
    logic [MOD_W-1:0]  dst_mod;
    logic [DSUB_W-1:0] dst_sub;
  } fields_t;

  typedef struct packed {
    logic              is_imm;
    logic [IMM_W-1:0]  imm;
    logic [MOD_W-1:0]  src_mod;
    logic [SIDX_W-1:0] src_idx;
    logic [MOD_W-1:0]  dst_mod;
    logic [DIDX_W-1:0] dst_idx;
  } move_t;
endpackage

// File: rtl/mvd_field_split.sv
module mvd_field_split
  import mvd_pkg::*;
#(
  parameter logic [MOD_W-1:0]  PFX_MOD = 4'hB,
  parameter logic [DSUB_W-1:0] PFX_SUB = 3'd0
) (
  input  logic [INSTR_W-1:0] instr_i,
  output fields_t            f_o,
  output logic               is_pfx_o
);
  always_comb begin
    f_o.is_imm  = ~instr_i[FMT_BIT];
    f_o.imm     = instr_i[IMM_W-1:0];
    f_o.src_mod = instr_i[MOD_W-1:0];
    f_o.src_idx = instr_i[MOD_W +: SIDX_W];
    f_o.dst_mod = instr_i[DST_LSB +: MOD_W];
    f_o.dst_sub = instr_i[DST_LSB+MOD_W +: DSUB_W];
  end

  assign is_pfx_o = (f_o.dst_mod == PFX_MOD) && (f_o.dst_sub == PFX_SUB);
endmodule

// File: rtl/mvd_prefix_reg.sv
module mvd_prefix_reg
  import mvd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             is_pfx_i,
  input  logic [PFX_W-1:0] wval_i,
  output logic [PFX_W-1:0] pfx_o
);
  logic [PFX_W-1:0] pfx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pfx_q <= '0;
    else if (valid_i && is_pfx_i) pfx_q <= wval_i;
    else if (valid_i)             pfx_q <= '0;  // one-shot: consumed by this move
  end

  assign pfx_o = pfx_q;

  p_pfx_oneshot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !is_pfx_i |=> pfx_q == '0);
  p_pfx_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_pfx_i |=> pfx_q == $past(wval_i));
  p_pfx_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(pfx_q));
endmodule

// File: rtl/mvd_out_stage.sv
module mvd_out_stage
  import mvd_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  move_t mv_i,
  output move_t mv_o,
  output logic  done_o
);
  move_t mv_q;
  logic  done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mv_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= load_i;
      if (load_i) mv_q <= mv_i;
    end
  end

  assign mv_o   = mv_q;
  assign done_o = done_q;

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(mv_q) && !done_q);
endmodule

// File: rtl/move_decoder.sv
module move_decoder
  import mvd_pkg::*;
#(
  parameter logic [MOD_W-1:0]  PFX_MOD = 4'hB,
  parameter logic [DSUB_W-1:0] PFX_SUB = 3'd0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               instr_valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [PFX_W-1:0]   pfx_wdata_i,
  output logic               mv_done_o,
  output logic               src_is_imm_o,
  output logic [IMM_W-1:0]   imm_o,
  output logic [MOD_W-1:0]   src_mod_o,
  output logic [SIDX_W-1:0]  src_idx_o,
  output logic [MOD_W-1:0]   dst_mod_o,
  output logic [DIDX_W-1:0]  dst_idx_o
);
  fields_t          f;
  logic             is_pfx;
  logic [PFX_W-1:0] pfx_wval, pfx_cur;
  move_t            mv_d, mv_q;
  logic             load;

  mvd_field_split #(.PFX_MOD(PFX_MOD), .PFX_SUB(PFX_SUB)) u_split (
    .instr_i (instr_i),
    .f_o     (f),
    .is_pfx_o(is_pfx)
  );

  // immediate-form prefix takes its value from the literal, register form from the side port
  assign pfx_wval = f.is_imm ? f.imm[PFX_W-1:0] : pfx_wdata_i;

  mvd_prefix_reg u_pfx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (instr_valid_i),
    .is_pfx_i(is_pfx),
    .wval_i  (pfx_wval),
    .pfx_o   (pfx_cur)
  );

  always_comb begin
    mv_d.is_imm  = f.is_imm;
    mv_d.imm     = f.is_imm ? f.imm     : '0;
    mv_d.src_mod = f.is_imm ? '0        : f.src_mod;
    mv_d.src_idx = f.is_imm ? '0        : f.src_idx;
    mv_d.dst_mod = f.dst_mod;
    mv_d.dst_idx = {pfx_cur, f.dst_sub};
  end

  assign load = instr_valid_i && !is_pfx;

  mvd_out_stage u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .mv_i  (mv_d),
    .mv_o  (mv_q),
    .done_o(mv_done_o)
  );

  assign src_is_imm_o = mv_q.is_imm;
  assign imm_o        = mv_q.imm;
  assign src_mod_o    = mv_q.src_mod;
  assign src_idx_o    = mv_q.src_idx;
  assign dst_mod_o    = mv_q.dst_mod;
  assign dst_idx_o    = mv_q.dst_idx;

  p_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && !is_pfx |=> mv_done_o);
  p_pfx_no_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && is_pfx |=> !mv_done_o && $stable(dst_idx_o));
  p_imm_src_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mv_done_o && src_is_imm_o |-> src_mod_o == '0 && src_idx_o == '0);
  p_reg_imm_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mv_done_o && !src_is_imm_o |-> imm_o == '0);
  p_dst_mod_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && !is_pfx |=> dst_mod_o == $past(instr_i[DST_LSB +: MOD_W]));
endmodule

// File: tb/tb_move_decoder.sv
`timescale 1ns/1ps
module tb_move_decoder;
  typedef struct packed {
    logic       imm_f;
    logic [7:0] imm;
    logic [3:0] smod;
    logic [3:0] sidx;
    logic [3:0] dmod;
    logic [4:0] didx;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [1:0]  pfx_wdata_i = '0;
  logic        mv_done_o, src_is_imm_o;
  logic [7:0]  imm_o;
  logic [3:0]  src_mod_o, src_idx_o, dst_mod_o;
  logic [4:0]  dst_idx_o;

  int   n_chk = 0, n_fail = 0;
  exp_t exp_q[$];
  string tag_q[$];
  exp_t last_e = '0;
  logic [1:0] pend = '0;

  always #10 clk = ~clk;

  move_decoder dut (
    .clk_i(clk), .rst_ni(rst_ni), .instr_valid_i(instr_valid_i), .instr_i(instr_i),
    .pfx_wdata_i(pfx_wdata_i), .mv_done_o(mv_done_o), .src_is_imm_o(src_is_imm_o),
    .imm_o(imm_o), .src_mod_o(src_mod_o), .src_idx_o(src_idx_o),
    .dst_mod_o(dst_mod_o), .dst_idx_o(dst_idx_o)
  );

  function automatic exp_t act();
    return {src_is_imm_o, imm_o, src_mod_o, src_idx_o, dst_mod_o, dst_idx_o};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && mv_done_o) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected done", 32'(act()), 32'h0);
      else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(act() == e, t, 32'(act()), 32'(e));
      end
    end
  end

  // driver: non-prefix move, starts and ends at a negedge
  task automatic mv(input logic [15:0] w, input string tag);
    exp_t e;
    e.imm_f = ~w[15];
    e.imm   = w[15] ? 8'h0 : w[7:0];
    e.smod  = w[15] ? w[3:0] : 4'h0;
    e.sidx  = w[15] ? w[7:4] : 4'h0;
    e.dmod  = w[11:8];
    e.didx  = {pend, w[14:12]};
    pend    = '0;
    last_e  = e;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    instr_i = w;
    instr_valid_i = 1'b1;
    @(negedge clk);
    instr_valid_i = 1'b0;
    instr_i = $urandom;
  endtask

  task automatic pfx(input logic [1:0] v, input bit regform, input string tag);
    instr_i = regform ? {1'b1, 3'd0, 4'hB, 8'h5C} : {1'b0, 3'd0, 4'hB, 6'h2A, v};
    pfx_wdata_i = regform ? v : ~v;
    instr_valid_i = 1'b1;
    pend = v;
    @(negedge clk);
    instr_valid_i = 1'b0;
    chk(mv_done_o == 1'b0, {tag, " no done"}, 32'(mv_done_o), 32'h0);
    chk(act() == last_e, {tag, " hold"}, 32'(act()), 32'(last_e));
  endtask

  task automatic idle(input int n, input logic [15:0] w);
    for (int i = 0; i < n; i++) begin
      instr_i = w;
      instr_valid_i = 1'b0;
      @(negedge clk);
      chk(mv_done_o == 1'b0 && act() == last_e, "R9 idle hold", 32'(act()), 32'(last_e));
    end
  endtask

  initial begin
    #(20 * 100000);
    chk(1'b0, "watchdog", 32'h0, 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(act() == '0 && mv_done_o == 1'b0, "R1 reset state", 32'(act()), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    mv(16'h3A7E, "R3 R5 imm move after reset");
    mv(16'hD2C4, "R4 reg move");
    mv(16'h0100, "R2 b2b 1");
    mv(16'hF3FF, "R2 b2b 2");
    mv(16'h7E81, "R2 b2b 3");
    idle(2, 16'h0B03);
    pfx(2'd2, 1'b0, "R6 imm prefix");
    idle(2, 16'h0B01);
    mv(16'h5512, "R7 R5 prefix used after idle");
    mv(16'h5512, "R7 prefix cleared");
    pfx(2'd3, 1'b1, "R6 reg prefix");
    pfx(2'd1, 1'b0, "R8 second prefix");
    mv(16'hE9A3, "R8 latest prefix wins");
    pfx(2'd1, 1'b1, "R8 imm then reg a");
    mv(16'h0B04 | 16'h1000, "R5 subindex 1 of prefix module is a move");
    for (int v = 0; v < 4; v++) begin
      pfx(2'(v), v[0], "R6 sweep prefix");
      mv({1'b1, 3'(7 - v), 4'(v + 3), 8'h96}, "R5 sweep move");
    end
    pfx(2'd3, 1'b0, "R1 prefix before reset");
    rst_ni = 1'b0;
    pend = '0;
    last_e = '0;
    @(negedge clk);
    chk(act() == '0 && mv_done_o == 1'b0, "R1 mid reset", 32'(act()), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    mv(16'h2C40, "R1 prefix discarded by reset");
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all moves completed", 32'(exp_q.size()), 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule